// File: doc/BRIEF.md
# Memory-Mapped SPI Flash Command Engine

This block turns a single-byte bus access aimed at a flash window into a complete SPI NOR transaction, with no software sequencing of the individual phases. The request carries a select number, a direction and a window offset. The engine reads the control word of that select and runs the phases in order: an opcode byte, an optional address of three or four bytes taken from the offset, a number of dummy bytes, and one data byte. The data byte is written from the request or read back into the response.

Opcode, address and dummy phases always use one line. The data phase uses one, two or four lines, as the control word selects. A shared phase-mask byte can remove the address phase, the data phase, or both. This gives command-only, command-plus-address and command-plus-data operations. The engine rejects a request that does not match the select's configured mode. A rejected request completes at once and produces no bus activity.

The SPI clock runs at half the system clock in mode 0. Data moves most significant bit first. After every transaction the chip select stays high for at least one SPI clock.

Top module: `sfc_cmd_engine`

## Requirements
- R1: A read is accepted only when control bits [1:0] of the addressed select are 01. A write is accepted only when they are 10 and bit 16+sel of the type register is set. A request is rejected if mode 11 or 00 is set, if control bit 2 is set, or if the select number is not below NUM_CS. A rejected request raises rsp_valid one cycle after the accepting edge, with rsp_rdata 0, and produces no chip-select or clock activity.
- R2: The first 8 SPI clocks carry the opcode from control bits [23:16], MSB first, on io line 0, with only line 0 enabled.
- R3: The address phase carries req_offset, MSB first, on io line 0. It is 4 bytes long when addr_mode bit sel or bit sel+4 is set, and 3 bytes long (offset bits [23:0]) otherwise.
- R4: When any bit of phase_mask[7:4] is set, the address phase is omitted.
- R5: The dummy phase lasts 8 SPI clocks per dummy byte. The dummy byte count is {ctrl[14], ctrl[7:6]}, from 0 to 7. No io line is enabled during this phase.
- R6: The data lane count is four when ctrl[30] is set (this bit takes priority), two when only ctrl[29] is set, and one otherwise. A write drives its byte MSB first, with the highest-numbered enabled line carrying the most significant bit of each group.
- R7: A read enables no io line during the data phase. It samples io1 in single mode, io[1:0] in dual mode and io[3:0] in quad mode, at the end of each SPI-clock high phase, and returns the assembled byte MSB first on rsp_rdata.
- R8: When any bit of phase_mask[3:0] is set, the data phase is omitted and rsp_rdata is 0.
- R9: sck is high for exactly one system cycle per SPI clock and low for at least one cycle between high pulses. For a transaction of N SPI clocks, rsp_valid is high for one cycle, right after the (2N+2)th edge following the accepting edge.
- R10: Only the addressed select line goes low. sck stays low and all io enables stay off while no select is active. After the last SPI clock, the select stays high for at least two cycles before the next transaction starts.
- R11: Requests that arrive while a transaction is in progress are ignored and produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request, sampled while idle |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_sel | input | SEL_W | Target select number |
| req_offset | input | OFS_W | Byte offset inside the select's window |
| req_wdata | input | 8 | Write data byte |
| busy | output | 1 | Transaction in progress |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read data byte (0 for writes and rejects) |
| ctrl_regs | input | NUM_CS*32 | Per-select control words, select g at bits [32g+31:32g] |
| addr_mode | input | 8 | Address width bits, pair sel / sel+4 |
| type_reg | input | 32 | Write-enable bits at 16+sel |
| phase_mask | input | 8 | Address/data phase suppression |
| spi_sck | output | 1 | SPI clock, mode 0 |
| spi_cs_n | output | NUM_CS | Active-low selects |
| spi_io_out | output | 4 | IO line output values |
| spi_io_oe | output | 4 | IO line output enables |
| spi_io_in | input | 4 | IO line input values |

## Verification
A rejected access completes in the cycle after its accepting edge. An accepted one needs two cycles for every SPI clock plus two gap cycles. Its rsp_valid is therefore due 2N+3 falling clock edges after the request is driven, where the bench computes N from the mask, address-width, dummy and lane settings. The bench counts falling edges up to the response and compares the count with that figure. It also records each rising sck edge to check the clock count and the value of every line. Read data is driven from a counter of falling sck edges, so each group is stable across the sampling edge.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_CMD   = 3'd1,
      PH_ADDR  = 3'd2,
      PH_DUMMY = 3'd3,
      PH_DATA  = 3'd4,
      PH_GAP   = 3'd5
   } phase_e;

   // Decoded per-access plan.
   typedef struct packed {
      logic [7:0] opcode;
      logic [1:0] lanes_log;   // 0 single, 1 dual, 2 quad
      logic       four_byte;
      logic       addr_on;
      logic       data_on;
      logic [2:0] dummy;
   } plan_t;

   localparam logic [1:0] MODE_RD  = 2'b01;
   localparam logic [1:0] MODE_WR  = 2'b10;
   localparam int         WEN_BASE = 16;
   localparam int         CTRL_W   = 32;

endpackage

// File: rtl/sfc_cfg_decode.sv
module sfc_cfg_decode
   import sfc_pkg::*;
#(
   parameter int NUM_CS = 3,
   parameter int SEL_W  = 2
) (
   input  logic [NUM_CS*CTRL_W-1:0] ctrl_regs,
   input  logic [7:0]               addr_mode,
   input  logic [31:0]              type_reg,
   input  logic [7:0]               phase_mask,
   input  logic                     req_write,
   input  logic [SEL_W-1:0]         req_sel,
   output logic                     accept,
   output plan_t                    plan
);

   logic [NUM_CS-1:0] hit;
   logic [NUM_CS-1:0] wen_v;
   logic [NUM_CS-1:0] four_v;
   logic [CTRL_W-1:0] word;
   logic              wen;
   logic              four;
   logic              unused_bits;

   generate
      for (genvar g = 0; g < NUM_CS; g++) begin : g_sel
         assign hit[g]    = (req_sel == SEL_W'(g));
         assign wen_v[g]  = type_reg[WEN_BASE+g];
         assign four_v[g] = addr_mode[g] | addr_mode[g+4];
      end
   endgenerate

   always_comb begin
      word = '0;
      for (int i = 0; i < NUM_CS; i++) begin
         if (hit[i]) word = word | ctrl_regs[i*CTRL_W +: CTRL_W];
      end
   end

   assign wen  = |(hit & wen_v);
   assign four = |(hit & four_v);

   assign accept = (|hit) & ~word[2] &
                   (req_write ? ((word[1:0] == MODE_WR) & wen)
                              : (word[1:0] == MODE_RD));

   always_comb begin
      plan.opcode    = word[23:16];
      plan.lanes_log = word[30] ? 2'd2 : (word[29] ? 2'd1 : 2'd0);
      plan.four_byte = four;
      plan.addr_on   = ~(|phase_mask[7:4]);
      plan.data_on   = ~(|phase_mask[3:0]);
      plan.dummy     = {word[14], word[7:6]};
   end

   assign unused_bits = ^{type_reg, addr_mode, word};

endmodule

// File: rtl/sfc_lane_map.sv
module sfc_lane_map
   import sfc_pkg::*;
(
   input  phase_e     phase,
   input  logic       write,
   input  logic [1:0] lanes_log,
   input  logic [3:0] top,
   input  logic [3:0] io_in,
   output logic [3:0] io_out,
   output logic [3:0] io_oe,
   output logic [3:0] sample,
   output logic [2:0] step
);

   always_comb begin
      io_out = 4'b0;
      io_oe  = 4'b0;
      step   = 3'd1;
      case (lanes_log)
         2'd2:    sample = io_in;
         2'd1:    sample = {2'b0, io_in[1:0]};
         default: sample = {3'b0, io_in[1]};
      endcase
      case (phase)
         PH_CMD, PH_ADDR: begin
            io_out = {3'b0, top[3]};
            io_oe  = 4'b0001;
         end
         PH_DATA: begin
            step = 3'd1 << lanes_log;
            if (write) begin
               case (lanes_log)
                  2'd2: begin
                     io_out = top;
                     io_oe  = 4'b1111;
                  end
                  2'd1: begin
                     io_out = {2'b0, top[3:2]};
                     io_oe  = 4'b0011;
                  end
                  default: begin
                     io_out = {3'b0, top[3]};
                     io_oe  = 4'b0001;
                  end
               endcase
            end
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/sfc_phase_seq.sv
module sfc_phase_seq
   import sfc_pkg::*;
#(
   parameter int NUM_CS = 3,
   parameter int SEL_W  = 2,
   parameter int OFS_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              accept,
   input  plan_t             plan_in,
   input  logic [SEL_W-1:0]  sel,
   input  logic              write,
   input  logic [OFS_W-1:0]  offset,
   input  logic [7:0]        wdata,
   input  logic [3:0]        sample,
   input  logic [2:0]        step,
   output phase_e            phase_o,
   output logic              write_o,
   output logic [1:0]        lanes_o,
   output logic [3:0]        sreg_top,
   output logic              sck,
   output logic [NUM_CS-1:0] cs_n,
   output logic              busy,
   output logic              rsp_valid,
   output logic [7:0]        rsp_rdata
);

   localparam int CNT_W = 6;

   phase_e           ph;
   logic             half;
   logic [CNT_W-1:0] cnt;
   logic [31:0]      sreg;
   logic [7:0]       rbuf;
   plan_t            pl;
   logic             wr;
   logic [31:0]      addr_q;
   logic [7:0]       wd_q;

   phase_e           adv_ph;
   logic [CNT_W-1:0] adv_cnt;
   logic [31:0]      adv_sreg;
   logic             past_addr;
   logic             past_dummy;

   // Next phase once the current one has sent its last clock.
   always_comb begin
      past_addr  = ((ph == PH_CMD) & ~pl.addr_on) | (ph == PH_ADDR);
      past_dummy = (past_addr & (pl.dummy == 3'd0)) | (ph == PH_DUMMY);
      adv_ph     = PH_GAP;
      adv_cnt    = '0;
      adv_sreg   = '0;
      if ((ph == PH_CMD) & pl.addr_on) begin
         adv_ph   = PH_ADDR;
         adv_cnt  = pl.four_byte ? CNT_W'(31) : CNT_W'(23);
         adv_sreg = pl.four_byte ? addr_q : {addr_q[23:0], 8'h00};
      end else if (past_addr & (pl.dummy != 3'd0)) begin
         adv_ph  = PH_DUMMY;
         adv_cnt = CNT_W'({pl.dummy, 3'b000}) - CNT_W'(1);
      end else if (past_dummy & pl.data_on) begin
         adv_ph   = PH_DATA;
         adv_sreg = {wd_q, 24'h0};
         case (pl.lanes_log)
            2'd2:    adv_cnt = CNT_W'(1);
            2'd1:    adv_cnt = CNT_W'(3);
            default: adv_cnt = CNT_W'(7);
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph        <= PH_IDLE;
         half      <= 1'b0;
         cnt       <= '0;
         sreg      <= '0;
         rbuf      <= '0;
         pl        <= '0;
         wr        <= 1'b0;
         addr_q    <= '0;
         wd_q      <= '0;
         sck       <= 1'b0;
         cs_n      <= '1;
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= 1'b0;
         case (ph)
            PH_IDLE: begin
               if (start) begin
                  if (accept) begin
                     ph     <= PH_CMD;
                     half   <= 1'b0;
                     cnt    <= CNT_W'(7);
                     sreg   <= {plan_in.opcode, 24'h0};
                     pl     <= plan_in;
                     wr     <= write;
                     addr_q <= 32'(offset);
                     wd_q   <= wdata;
                     rbuf   <= '0;
                     cs_n   <= ~(NUM_CS'(1) << sel);
                  end else begin
                     rsp_valid <= 1'b1;
                     rsp_rdata <= '0;
                  end
               end
            end
            PH_GAP: begin
               if (!half) begin
                  half <= 1'b1;
               end else begin
                  half      <= 1'b0;
                  ph        <= PH_IDLE;
                  rsp_valid <= 1'b1;
                  rsp_rdata <= wr ? 8'h00 : rbuf;
               end
            end
            default: begin
               if (!half) begin
                  sck  <= 1'b1;
                  half <= 1'b1;
               end else begin
                  sck  <= 1'b0;
                  half <= 1'b0;
                  if ((ph == PH_DATA) & ~wr) rbuf <= (rbuf << step) | {4'b0, sample};
                  if (cnt == '0) begin
                     ph   <= adv_ph;
                     cnt  <= adv_cnt;
                     sreg <= adv_sreg;
                     if (adv_ph == PH_GAP) cs_n <= '1;
                  end else begin
                     cnt  <= cnt - CNT_W'(1);
                     sreg <= sreg << step;
                  end
               end
            end
         endcase
      end
   end

   assign phase_o  = ph;
   assign write_o  = wr;
   assign lanes_o  = pl.lanes_log;
   assign sreg_top = sreg[31:28];
   assign busy     = (ph != PH_IDLE);

endmodule

// File: rtl/sfc_cmd_engine.sv
module sfc_cmd_engine
   import sfc_pkg::*;
#(
   parameter int NUM_CS = 3,
   parameter int SEL_W  = 2,
   parameter int OFS_W  = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   input  logic                     req_write,
   input  logic [SEL_W-1:0]         req_sel,
   input  logic [OFS_W-1:0]         req_offset,
   input  logic [7:0]               req_wdata,
   output logic                     busy,
   output logic                     rsp_valid,
   output logic [7:0]               rsp_rdata,
   input  logic [NUM_CS*CTRL_W-1:0] ctrl_regs,
   input  logic [7:0]               addr_mode,
   input  logic [31:0]              type_reg,
   input  logic [7:0]               phase_mask,
   output logic                     spi_sck,
   output logic [NUM_CS-1:0]        spi_cs_n,
   output logic [3:0]               spi_io_out,
   output logic [3:0]               spi_io_oe,
   input  logic [3:0]               spi_io_in
);

   generate
      if (NUM_CS < 1 || NUM_CS > 4) begin : g_bad_cs
         $error("NUM_CS must be 1..4");
      end
      if ((1 << SEL_W) < NUM_CS) begin : g_bad_sel
         $error("SEL_W too narrow for NUM_CS");
      end
      if (OFS_W < 24 || OFS_W > 32) begin : g_bad_ofs
         $error("OFS_W must be 24..32");
      end
   endgenerate

   logic       acc;
   plan_t      plan;
   phase_e     phase;
   logic       wr_q;
   logic [1:0] lanes_q;
   logic [3:0] top;
   logic [3:0] sample;
   logic [2:0] step;

   sfc_cfg_decode #(.NUM_CS(NUM_CS), .SEL_W(SEL_W)) u_dec (
      .ctrl_regs (ctrl_regs),
      .addr_mode (addr_mode),
      .type_reg  (type_reg),
      .phase_mask(phase_mask),
      .req_write (req_write),
      .req_sel   (req_sel),
      .accept    (acc),
      .plan      (plan)
   );

   sfc_phase_seq #(.NUM_CS(NUM_CS), .SEL_W(SEL_W), .OFS_W(OFS_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (req_valid),
      .accept   (acc),
      .plan_in  (plan),
      .sel      (req_sel),
      .write    (req_write),
      .offset   (req_offset),
      .wdata    (req_wdata),
      .sample   (sample),
      .step     (step),
      .phase_o  (phase),
      .write_o  (wr_q),
      .lanes_o  (lanes_q),
      .sreg_top (top),
      .sck      (spi_sck),
      .cs_n     (spi_cs_n),
      .busy     (busy),
      .rsp_valid(rsp_valid),
      .rsp_rdata(rsp_rdata)
   );

   sfc_lane_map u_lane (
      .phase    (phase),
      .write    (wr_q),
      .lanes_log(lanes_q),
      .top      (top),
      .io_in    (spi_io_in),
      .io_out   (spi_io_out),
      .io_oe    (spi_io_oe),
      .sample   (sample),
      .step     (step)
   );

endmodule

// File: rtl/sfc_cmd_engine_chk.sv
module sfc_cmd_engine_chk #(
   parameter int NUM_CS = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              rsp_valid,
   input logic              spi_sck,
   input logic [NUM_CS-1:0] spi_cs_n,
   input logic [3:0]        spi_io_oe
);

   AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~spi_cs_n)); // R10

   AST_SCK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
      (&spi_cs_n) |-> !spi_sck); // R10

   AST_LINES_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (&spi_cs_n) |-> (spi_io_oe == 4'b0000)); // R10

   AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(&spi_cs_n) |=> (&spi_cs_n)); // R10

   AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid); // R9

   AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !busy); // R9

   AST_SCK_HIGH_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spi_sck) |=> $fell(spi_sck)); // R9

endmodule

bind sfc_cmd_engine sfc_cmd_engine_chk #(.NUM_CS(NUM_CS)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .busy     (busy),
   .rsp_valid(rsp_valid),
   .spi_sck  (spi_sck),
   .spi_cs_n (spi_cs_n),
   .spi_io_oe(spi_io_oe)
);

// File: tb/test_sfc_cmd_engine.sv
`timescale 1ns/1ps
module test_sfc_cmd_engine;

   localparam int NCS = 3;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           req_valid = 1'b0;
   logic           req_write = 1'b0;
   logic [1:0]     req_sel = '0;
   logic [31:0]    req_offset = '0;
   logic [7:0]     req_wdata = '0;
   logic           busy;
   logic           rsp_valid;
   logic [7:0]     rsp_rdata;
   logic [NCS*32-1:0] ctrl_regs = '0;
   logic [7:0]     addr_mode = '0;
   logic [31:0]    type_reg = '0;
   logic [7:0]     phase_mask = '0;
   logic           spi_sck;
   logic [NCS-1:0] spi_cs_n;
   logic [3:0]     spi_io_out;
   logic [3:0]     spi_io_oe;
   logic [3:0]     spi_io_in;

   int total = 0;
   int bad   = 0;
   bit finished = 0;

   // Flash model state
   logic [3:0]     got_io [128];
   logic [3:0]     got_oe [128];
   int             nclk = 0;
   int             jcnt = 0;
   logic [NCS-1:0] cs_seen = '1;
   logic [7:0]     rd_pat = '0;
   int             rd_lanes = 0;
   int             rd_start = 0;
   wire            anysel = ~&spi_cs_n;

   always #4 clk = ~clk;

   sfc_cmd_engine #(.NUM_CS(NCS), .SEL_W(2), .OFS_W(32)) i_sfc_cmd_engine (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_sel(req_sel), .req_offset(req_offset), .req_wdata(req_wdata),
      .busy(busy), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .ctrl_regs(ctrl_regs), .addr_mode(addr_mode), .type_reg(type_reg),
      .phase_mask(phase_mask), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
      .spi_io_out(spi_io_out), .spi_io_oe(spi_io_oe), .spi_io_in(spi_io_in)
   );

   always @(posedge anysel) begin
      jcnt    = 0;
      nclk    = 0;
      cs_seen = spi_cs_n;
   end

   always @(posedge spi_sck) begin
      got_io[nclk] = spi_io_out;
      got_oe[nclk] = spi_io_oe;
      if (nclk < 127) nclk++;
   end

   always @(negedge spi_sck) jcnt++;

   function automatic logic [3:0] flash_out(int j);
      int d;
      d = j - rd_start;
      if (d < 0 || d >= (8 >> rd_lanes)) return 4'b1010;
      case (rd_lanes)
         2:       return rd_pat[7-4*d -: 4];
         1:       return {2'b10, rd_pat[7-2*d -: 2]};
         default: return {2'b10, rd_pat[7-d], 1'b0};
      endcase
   endfunction

   assign spi_io_in = flash_out(jcnt);

   function automatic logic [31:0] mk_ctrl(logic [1:0] mode, bit stop, int dmy,
                                           logic [7:0] op, int lanes);
      logic [31:0] w;
      logic [2:0]  d3;
      d3       = dmy[2:0];
      w        = '0;
      w[1:0]   = mode;
      w[2]     = stop;
      w[7:6]   = d3[1:0];
      w[14]    = d3[2];
      w[23:16] = op;
      w[29]    = (lanes == 1);
      w[30]    = (lanes == 2);
      return w;
   endfunction

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Drive one request and wait for its response; returns falling edges counted.
   task automatic issue(input bit wr, input int sel, input logic [31:0] ofs,
                        input logic [7:0] wd, input bit interfere, output int cyc);
      @(negedge clk);
      nclk       = 0;
      req_valid  = 1'b1;
      req_write  = wr;
      req_sel    = sel[1:0];
      req_offset = ofs;
      req_wdata  = wd;
      cyc = 0;
      do begin
         @(negedge clk);
         cyc++;
         if (cyc == 1) req_valid = 1'b0;
         if (interfere && cyc == 6) begin
            req_valid = 1'b1;
            req_sel   = 2'(sel + 1);
         end
         if (interfere && cyc == 7) req_valid = 1'b0;
      end while (!rsp_valid && cyc < 1000);
   endtask

   task automatic run_tx(input bit wr, input int sel, input logic [31:0] ofs,
                         input logic [7:0] wd, input logic [7:0] pat,
                         input logic [7:0] op, input int lanes, input int dmy,
                         input bit fb, input bit am, input bit dm, input bit interfere);
      int abits, dbits, n, cyc;
      int mis_c, mis_a, mis_d, mis_x;
      bit extra;
      logic [3:0] ev, eo;
      abits    = am ? 0 : (fb ? 32 : 24);
      dbits    = dm ? 0 : (8 >> lanes);
      n        = 8 + abits + dmy*8 + dbits;
      rd_pat   = pat;
      rd_lanes = lanes;
      rd_start = 8 + abits + dmy*8;
      issue(wr, sel, ofs, wd, interfere, cyc);
      chk(cyc == 2*n+3, "R9 response cycle", cyc, 2*n+3);
      chk(nclk == n, am ? "R4 clock count" : (dm ? "R8 clock count" : "R5 clock count"), nclk, n);
      chk(cs_seen == ~(NCS'(1) << sel), "R10 select line", cs_seen, ~(NCS'(1) << sel));
      if (!wr && !dm) chk(rsp_rdata == pat, "R7 read data", rsp_rdata, pat);
      else chk(rsp_rdata == 8'h00, dm ? "R8 read data" : "R6 write rdata", rsp_rdata, 0);
      mis_c = 0; mis_a = 0; mis_d = 0; mis_x = 0;
      for (int k = 0; k < n && k < 128; k++) begin
         if (k < 8) begin
            if (got_oe[k] != 4'b0001 || got_io[k][0] != op[7-k]) mis_c++;
         end else if (k < 8 + abits) begin
            if (got_oe[k] != 4'b0001 || got_io[k][0] != ofs[abits-1-(k-8)]) mis_a++;
         end else if (k < rd_start) begin
            if (got_oe[k] != 4'b0000) mis_d++;
         end else begin
            int d;
            d = k - rd_start;
            case (lanes)
               2:       begin ev = wd[7-4*d -: 4];        eo = 4'hF; end
               1:       begin ev = {2'b0, wd[7-2*d -: 2]}; eo = 4'h3; end
               default: begin ev = {3'b0, wd[7-d]};        eo = 4'h1; end
            endcase
            if (!wr) eo = 4'h0;
            if (got_oe[k] != eo || ((got_io[k] & eo) != (ev & eo))) mis_x++;
         end
      end
      chk(mis_c == 0, "R2 opcode bits", mis_c, 0);
      if (abits != 0) chk(mis_a == 0, "R3 address bits", mis_a, 0);
      if (dmy != 0) chk(mis_d == 0, "R5 dummy lines", mis_d, 0);
      if (dbits != 0) chk(mis_x == 0, wr ? "R6 write lanes" : "R7 read lanes", mis_x, 0);
      if (interfere) begin
         extra = 0;
         for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (rsp_valid) extra = 1;
         end
         chk(!extra, "R11 busy request ignored", extra, 0);
      end
   endtask

   task automatic run_reject(input bit wr, input int sel, input string tag);
      int cyc;
      issue(wr, sel, 32'h0012_3456, 8'h5A, 0, cyc);
      chk(cyc == 1, tag, cyc, 1);
      chk(nclk == 0 && &spi_cs_n, tag, nclk, 0);
      chk(rsp_rdata == 8'h00, tag, rsp_rdata, 0);
      repeat (3) @(negedge clk);
   endtask

   task automatic set_sel(input int sel, input logic [31:0] w);
      for (int i = 0; i < NCS; i++) ctrl_regs[i*32 +: 32] = mk_ctrl(2'b11, 1, 3, 8'hEE, 2);
      if (sel < NCS) ctrl_regs[sel*32 +: 32] = w;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int idx;
      idx = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(&spi_cs_n && !spi_sck && spi_io_oe == 0, "R10 reset idle lines", {spi_cs_n, spi_sck}, 0);
      chk(!busy && !rsp_valid, "R9 reset no response", {busy, rsp_valid}, 0);

      // R1: rejection cases
      set_sel(0, mk_ctrl(2'b10, 0, 0, 8'h02, 0)); type_reg = 32'h1 << 16;
      run_reject(0, 0, "R1 read in write mode");
      set_sel(0, mk_ctrl(2'b01, 0, 0, 8'h03, 0)); type_reg = 32'h7 << 16;
      run_reject(1, 0, "R1 write in read mode");
      set_sel(1, mk_ctrl(2'b10, 0, 0, 8'h02, 0)); type_reg = 32'h5 << 16;
      run_reject(1, 1, "R1 write without enable");
      set_sel(2, mk_ctrl(2'b11, 0, 0, 8'h9F, 0));
      run_reject(0, 2, "R1 user mode");
      set_sel(1, mk_ctrl(2'b01, 1, 0, 8'h03, 0));
      run_reject(0, 1, "R1 stop bit");
      set_sel(0, mk_ctrl(2'b00, 0, 0, 8'h03, 0));
      run_reject(0, 0, "R1 mode zero");
      set_sel(3, 32'h0);
      run_reject(0, 3, "R1 select out of range");

      // Sweep over direction, lanes, address width, masks and dummy counts
      for (int dir = 0; dir < 2; dir++)
         for (int ln = 0; ln < 3; ln++)
            for (int fb = 0; fb < 2; fb++)
               for (int am = 0; am < 2; am++)
                  for (int dm = 0; dm < 2; dm++)
                     for (int di = 0; di < 3; di++) begin
                        int sel, dmy;
                        logic [7:0] op;
                        logic [31:0] ofs;
                        sel = idx % NCS;
                        dmy = (di == 0) ? 0 : ((di == 1) ? 1 : 7);
                        op  = 8'(8'h0B + idx * 5);
                        ofs = 32'hA5C3_1E69 ^ (idx * 32'h0102_0305);
                        set_sel(sel, mk_ctrl(dir ? 2'b10 : 2'b01, 0, dmy, op, ln));
                        type_reg  = dir ? (32'h1 << (16 + sel)) : 32'h0;
                        if (fb != 0) addr_mode = (idx % 2 != 0) ? (8'h10 << sel) : (8'h01 << sel);
                        else         addr_mode = 8'h77 & ~(8'h11 << sel);
                        phase_mask = (am != 0 ? (8'h10 << (idx % 4)) : 8'h00) |
                                     (dm != 0 ? (8'h01 << (idx % 4)) : 8'h00);
                        run_tx(dir != 0, sel, ofs, 8'(8'h3C ^ idx), 8'(8'h96 ^ (idx * 7)),
                               op, ln, dmy, fb != 0, am != 0, dm != 0, 0);
                        idx++;
                     end

      // R6: both lane bits set selects quad
      begin
         logic [31:0] w;
         w = mk_ctrl(2'b10, 0, 0, 8'h32, 2);
         w[29] = 1'b1;
         set_sel(1, w); type_reg = 32'h2 << 16; addr_mode = 8'h00; phase_mask = 8'h00;
         run_tx(1, 1, 32'h0044_1122, 8'hC5, 8'h00, 8'h32, 2, 0, 0, 0, 0, 0);
      end

      // R11: request during a long transaction
      set_sel(2, mk_ctrl(2'b01, 0, 7, 8'h6B, 1)); type_reg = 0; addr_mode = 8'h40; phase_mask = 0;
      for (int i = 0; i < NCS; i++) if (i != 2) ctrl_regs[i*32 +: 32] = mk_ctrl(2'b01, 0, 0, 8'h03, 0);
      run_tx(0, 2, 32'hDEAD_BEEF, 8'h00, 8'hE1, 8'h6B, 1, 7, 1, 0, 0, 1);

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule